// File: doc/BRIEF.md
# Colour Raster-Operation Block Transfer Engine

This engine draws one rectangle per command. A host loads a command word together with source and destination base addresses, separate line strides, a rectangle size, pattern colours and a mono pattern, then pulses `start`. The engine visits each destination pixel and reads the matching source pixel and the current destination pixel, one byte per cycle, through a byte-wide memory port. It merges source, destination and pattern with an 8-bit ternary raster operation and, if drawing is enabled, writes the result back over the destination.

Pixels can be 1, 2 or 3 bytes wide. The pattern tiles an 8x8 grid anchored at the rectangle's top-left pixel. It is taken either from a 192-byte colour table or from a 64-bit mono mask that picks a foreground or a background colour. The colour table is loaded through a separate byte write port. Addresses wrap modulo the size of the attached memory.

Top module: `blt_pixel_engine`

## Requirements
- R1: Command bits [4:2] set the pixel size: 0 selects 1 byte, 1 selects 2 bytes and 2 selects 3 bytes. Multi-byte pixels are stored least significant byte first.
- R2: Each base address is ANDed with 0x3FFFF8 and each stride with 0xFFF8. Byte i of pixel (x,y) lies at (base + x*bytes + y*stride + i) modulo 2^MEM_AW. Source reads use the source base and stride. Destination reads and writes use the destination base and stride.
- R3: When command bit 5 is 0, every pixel is still read and walked, but `memWe` never rises and memory is left unchanged.
- R4: The raster code is command bits [24:17]. Result bit j is code bit (P[j]*4 + S[j]*2 + D[j]), where P is pattern, S is source and D is destination. Supported codes are 0x00, 0x0A, 0x22, 0x55, 0xB8, 0xBB, 0xCC, 0xE2, 0xEE, 0xF0 and 0xFF.
- R5: Any other code writes the destination back unchanged. It also sets `ropFault` in the first cycle after the start is accepted. The flag holds until the next accepted start.
- R6: When command bit 8 is 1, the pattern is `patFg` if bit (row*8 + 7 - col) of `monoPat` is 1 and `patBg` otherwise. Only the low pixel-size bytes of the chosen colour are used.
- R7: When command bit 8 is 0, pattern byte i is colour-table entry row*8*bytes + col*bytes + i. The table is written one byte per cycle through `patWe`, `patAddr` and `patData`.
- R8: Pixels are visited left to right within a row and rows top to bottom, over widthM1+1 columns and heightM1+1 rows. The pattern column is x mod 8 and the pattern row is y mod 8, with (0,0) at the first pixel.
- R9: Each pixel takes `bytes` source reads, then `bytes` destination reads, one compute cycle, `bytes` writes when drawing is enabled, and one advance cycle. `done` is a one-cycle pulse in the last pixel's advance cycle. `busy` is high from the cycle after the accepted start through that cycle.
- R10: After reset the engine is idle, with `busy`, `done`, `ropFault`, `memRe` and `memWe` all low. A `start` that arrives while `busy` is high is ignored, along with the command inputs presented with it.
- R11: The memory port moves one byte per cycle. Read data must be on `memRdata` in the cycle after `memRe`. A read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| cmdWord | input | 32 | Command: size [4:2], draw [5], mono [8], raster code [24:17] |
| srcBase | input | 32 | Source base byte address |
| dstBase | input | 32 | Destination base byte address |
| srcStride | input | 16 | Source line pitch in bytes |
| dstStride | input | 16 | Destination line pitch in bytes |
| widthM1 | input | COORD_W | Columns minus one |
| heightM1 | input | COORD_W | Rows minus one |
| patFg | input | 24 | Mono pattern foreground colour |
| patBg | input | 24 | Mono pattern background colour |
| monoPat | input | 64 | 8x8 mono pattern mask |
| patWe | input | 1 | Colour-table byte write strobe |
| patAddr | input | 8 | Colour-table byte index (0..191) |
| patData | input | 8 | Colour-table byte value |
| memAddr | output | MEM_AW | Memory byte address |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write byte |
| memRdata | input | 8 | Memory read byte, valid the cycle after memRe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| ropFault | output | 1 | Sticky unsupported raster code flag |

## Verification
Counting the accepting clock edge as cycle 0, `ropFault` is valid in cycle 1. `done` is due in cycle P*(2b+2+d*b), where P is the pixel count, b the bytes per pixel and d the draw enable. `busy` and `done` must both be low one cycle later. The bench samples every output on the falling edge and counts cycles from the accepting edge, so each check lands in exactly the cycle its result is due. Memory contents are compared only after `done`, against a model that replays the walk pixel by pixel. That model also gives the right answer when source and destination overlap.

// File: rtl/blt_pkg.sv
package blt_pkg;
  parameter int COORD_W = 12;

  localparam int DEPTH_LSB   = 2;
  localparam int DRAW_BIT    = 5;
  localparam int MONO_BIT    = 8;
  localparam int ROP_LSB     = 17;
  localparam int PIX_MAX     = 3;
  localparam int PAT_BYTES   = 8 * 8 * PIX_MAX;
  localparam logic [31:0] BASE_MASK   = 32'h003F_FFF8;
  localparam logic [15:0] STRIDE_MASK = 16'hFFF8;

  typedef struct packed {
    logic               load;
    logic               rdSrc;
    logic               rdDst;
    logic               wr;
    logic [1:0]         byteIdx;
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } blt_strobe_t;

  function automatic logic ropKnown(input logic [7:0] code);
    case (code)
      8'h00, 8'h0A, 8'h22, 8'h55, 8'hB8, 8'hBB,
      8'hCC, 8'hE2, 8'hEE, 8'hF0, 8'hFF: ropKnown = 1'b1;
      default:                           ropKnown = 1'b0;
    endcase
  endfunction

  function automatic logic [23:0] ropEval(input logic [7:0] code,
                                          input logic [23:0] s,
                                          input logic [23:0] d,
                                          input logic [23:0] p);
    case (code)
      8'h00:   ropEval = '0;
      8'h0A:   ropEval = d & ~p;
      8'h22:   ropEval = d & ~s;
      8'h55:   ropEval = ~d;
      8'hB8:   ropEval = ((d ^ p) & s) ^ p;
      8'hBB:   ropEval = d | ~s;
      8'hCC:   ropEval = s;
      8'hE2:   ropEval = ((p ^ d) & s) ^ d;
      8'hEE:   ropEval = d | s;
      8'hF0:   ropEval = p;
      8'hFF:   ropEval = '1;
      default: ropEval = d;
    endcase
  endfunction
endpackage

// File: rtl/blt_ctrl.sv
module blt_ctrl
  import blt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         cfgBytes,
  input  logic               cfgDraw,
  input  logic [COORD_W-1:0] cfgWM1,
  input  logic [COORD_W-1:0] cfgHM1,
  output blt_strobe_t        stb,
  output logic               busy,
  output logic               done
);
  typedef enum logic [2:0] {
    S_IDLE, S_RDS, S_RDD, S_CALC, S_WR, S_ADV
  } state_t;

  state_t             state;
  logic [1:0]         byteCnt;
  logic [COORD_W-1:0] xCur;
  logic [COORD_W-1:0] yCur;
  logic               lastByte;
  logic               lastCol;
  logic               lastPix;

  assign lastByte = (byteCnt == cfgBytes - 2'd1);
  assign lastCol  = (xCur == cfgWM1);
  assign lastPix  = lastCol && (yCur == cfgHM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      byteCnt <= '0;
      xCur    <= '0;
      yCur    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_RDS;
          byteCnt <= '0;
          xCur    <= '0;
          yCur    <= '0;
        end
        S_RDS: if (lastByte) begin
          byteCnt <= '0;
          state   <= S_RDD;
        end else byteCnt <= byteCnt + 2'd1;
        S_RDD: if (lastByte) begin
          byteCnt <= '0;
          state   <= S_CALC;
        end else byteCnt <= byteCnt + 2'd1;
        S_CALC: state <= cfgDraw ? S_WR : S_ADV;
        S_WR: if (lastByte) begin
          byteCnt <= '0;
          state   <= S_ADV;
        end else byteCnt <= byteCnt + 2'd1;
        S_ADV: begin
          if (lastPix) state <= S_IDLE;
          else begin
            state <= S_RDS;
            if (lastCol) begin
              xCur <= '0;
              yCur <= yCur + 1'b1;
            end else xCur <= xCur + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load    = (state == S_IDLE) && start;
    stb.rdSrc   = (state == S_RDS);
    stb.rdDst   = (state == S_RDD);
    stb.wr      = (state == S_WR);
    stb.byteIdx = byteCnt;
    stb.x       = xCur;
    stb.y       = yCur;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_ADV) && lastPix;
endmodule

// File: rtl/blt_datapath.sv
module blt_datapath
  import blt_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  blt_strobe_t        stb,
  input  logic [31:0]        cmdWord,
  input  logic [31:0]        srcBase,
  input  logic [31:0]        dstBase,
  input  logic [15:0]        srcStride,
  input  logic [15:0]        dstStride,
  input  logic [COORD_W-1:0] widthM1,
  input  logic [COORD_W-1:0] heightM1,
  input  logic [23:0]        patFg,
  input  logic [23:0]        patBg,
  input  logic [63:0]        monoPat,
  input  logic               patWe,
  input  logic [7:0]         patAddr,
  input  logic [7:0]         patData,
  input  logic [7:0]         memRdata,
  output logic [MEM_AW-1:0]  memAddr,
  output logic               memRe,
  output logic               memWe,
  output logic [7:0]         memWdata,
  output logic [1:0]         cfgBytes,
  output logic               cfgDraw,
  output logic [COORD_W-1:0] cfgWM1,
  output logic [COORD_W-1:0] cfgHM1,
  output logic               ropFault
);
  logic [1:0]  bytesQ;
  logic [7:0]  ropQ;
  logic        drawQ, monoQ, faultQ;
  logic [31:0] srcBaseQ, dstBaseQ;
  logic [15:0] srcStrQ, dstStrQ;
  logic [COORD_W-1:0] wM1Q, hM1Q;
  logic [23:0] fgQ, bgQ;
  logic [63:0] monoMaskQ;
  logic [7:0]  patTab [PAT_BYTES];
  logic [23:0] srcPix, dstPix;
  logic        capSrc, capDst;
  logic [1:0]  capIdx;
  logic [1:0]  bytesIn;

  logic unusedBits;
  assign unusedBits = ^{cmdWord[31:25], cmdWord[16:9], cmdWord[7:6], cmdWord[1:0]};

  always_comb begin
    case (cmdWord[DEPTH_LSB +: 3])
      3'd0:    bytesIn = 2'd1;
      3'd1:    bytesIn = 2'd2;
      default: bytesIn = 2'd3;
    endcase
  end

  // configuration latched once per accepted command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bytesQ    <= 2'd1;
      ropQ      <= '0;
      drawQ     <= 1'b0;
      monoQ     <= 1'b0;
      faultQ    <= 1'b0;
      srcBaseQ  <= '0;
      dstBaseQ  <= '0;
      srcStrQ   <= '0;
      dstStrQ   <= '0;
      wM1Q      <= '0;
      hM1Q      <= '0;
      fgQ       <= '0;
      bgQ       <= '0;
      monoMaskQ <= '0;
    end else if (stb.load) begin
      bytesQ    <= bytesIn;
      ropQ      <= cmdWord[ROP_LSB +: 8];
      drawQ     <= cmdWord[DRAW_BIT];
      monoQ     <= cmdWord[MONO_BIT];
      faultQ    <= !ropKnown(cmdWord[ROP_LSB +: 8]);
      srcBaseQ  <= srcBase & BASE_MASK;
      dstBaseQ  <= dstBase & BASE_MASK;
      srcStrQ   <= srcStride & STRIDE_MASK;
      dstStrQ   <= dstStride & STRIDE_MASK;
      wM1Q      <= widthM1;
      hM1Q      <= heightM1;
      fgQ       <= patFg;
      bgQ       <= patBg;
      monoMaskQ <= monoPat;
    end
  end

  always_ff @(posedge clk) begin
    if (patWe && (patAddr < 8'(PAT_BYTES))) patTab[patAddr] <= patData;
  end

  // read-data capture lags the request by one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capSrc <= 1'b0;
      capDst <= 1'b0;
      capIdx <= '0;
      srcPix <= '0;
      dstPix <= '0;
    end else begin
      capSrc <= stb.rdSrc;
      capDst <= stb.rdDst;
      capIdx <= stb.byteIdx;
      if (capSrc) srcPix[{capIdx, 3'b000} +: 8] <= memRdata;
      if (capDst) dstPix[{capIdx, 3'b000} +: 8] <= memRdata;
    end
  end

  // addressing
  logic [31:0] xOff, srcFull, dstFull;
  assign xOff    = 32'(stb.x) * 32'(bytesQ) + 32'(stb.byteIdx);
  assign srcFull = srcBaseQ + xOff + 32'(stb.y) * 32'(srcStrQ);
  assign dstFull = dstBaseQ + xOff + 32'(stb.y) * 32'(dstStrQ);
  assign memAddr = stb.rdSrc ? srcFull[MEM_AW-1:0] : dstFull[MEM_AW-1:0];
  assign memRe   = stb.rdSrc | stb.rdDst;
  assign memWe   = stb.wr;

  // pattern fetch
  logic [7:0]  patIdx0;
  logic [23:0] colourPat, patVal;
  logic        monoHit;
  assign patIdx0 = ({5'd0, stb.y[2:0]} * {6'd0, bytesQ}) * 8'd8
                 + {5'd0, stb.x[2:0]} * {6'd0, bytesQ};

  for (genvar g = 0; g < PIX_MAX; g++) begin : g_lane
    logic [7:0] laneIdx;
    assign laneIdx = patIdx0 + 8'(g);
    assign colourPat[g*8 +: 8] =
      ((2'(g) < bytesQ) && (laneIdx < 8'(PAT_BYTES))) ? patTab[laneIdx] : 8'h00;
  end

  assign monoHit = monoMaskQ[{stb.y[2:0], ~stb.x[2:0]}];
  assign patVal  = monoQ ? (monoHit ? fgQ : bgQ) : colourPat;

  logic [23:0] result;
  assign result   = ropEval(ropQ, srcPix, dstPix, patVal);
  assign memWdata = result[{stb.byteIdx, 3'b000} +: 8];

  assign cfgBytes = bytesQ;
  assign cfgDraw  = drawQ;
  assign cfgWM1   = wM1Q;
  assign cfgHM1   = hM1Q;
  assign ropFault = faultQ;
endmodule

// File: rtl/blt_pixel_engine.sv
module blt_pixel_engine
  import blt_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [31:0]        cmdWord,
  input  logic [31:0]        srcBase,
  input  logic [31:0]        dstBase,
  input  logic [15:0]        srcStride,
  input  logic [15:0]        dstStride,
  input  logic [COORD_W-1:0] widthM1,
  input  logic [COORD_W-1:0] heightM1,
  input  logic [23:0]        patFg,
  input  logic [23:0]        patBg,
  input  logic [63:0]        monoPat,
  input  logic               patWe,
  input  logic [7:0]         patAddr,
  input  logic [7:0]         patData,
  output logic [MEM_AW-1:0]  memAddr,
  output logic               memRe,
  output logic               memWe,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata,
  output logic               busy,
  output logic               done,
  output logic               ropFault
);
  blt_strobe_t        stb;
  logic [1:0]         cfgBytes;
  logic               cfgDraw;
  logic [COORD_W-1:0] cfgWM1, cfgHM1;

  blt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgBytes(cfgBytes), .cfgDraw(cfgDraw), .cfgWM1(cfgWM1), .cfgHM1(cfgHM1),
    .stb(stb), .busy(busy), .done(done)
  );

  blt_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdWord(cmdWord), .srcBase(srcBase), .dstBase(dstBase),
    .srcStride(srcStride), .dstStride(dstStride),
    .widthM1(widthM1), .heightM1(heightM1),
    .patFg(patFg), .patBg(patBg), .monoPat(monoPat),
    .patWe(patWe), .patAddr(patAddr), .patData(patData),
    .memRdata(memRdata), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .cfgBytes(cfgBytes), .cfgDraw(cfgDraw),
    .cfgWM1(cfgWM1), .cfgHM1(cfgHM1), .ropFault(ropFault)
  );
endmodule

// File: rtl/blt_checker.sv
module blt_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic cmdDraw,
  input logic busy,
  input logic done,
  input logic memRe,
  input logic memWe,
  input logic ropFault
);
  logic drawSeen;
  always_ff @(posedge clk) begin
    if (!rstN) drawSeen <= 1'b0;
    else if (start && !busy) drawSeen <= cmdDraw;
  end

  AST_WE_NEEDS_DRAW: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> drawSeen);                                          // R3
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ropFault && !(start && !busy)) |=> ropFault);                // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                              // R9
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);                                              // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);                                               // R9
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);                                   // R10
  AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> busy);                                   // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));                                           // R11
endmodule

bind blt_pixel_engine blt_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .cmdDraw(cmdWord[5]),
  .busy(busy), .done(done), .memRe(memRe), .memWe(memWe), .ropFault(ropFault)
);

// File: tb/blt_pixel_engine_tb.sv
`timescale 1ns/1ps
module blt_pixel_engine_tb;
  localparam int MEM_AW = 12;
  localparam int MEMN   = 1 << MEM_AW;
  localparam int CW     = blt_pkg::COORD_W;
  localparam int LIMIT  = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] cmdWord = '0, srcBase = '0, dstBase = '0;
  logic [15:0] srcStride = '0, dstStride = '0;
  logic [CW-1:0] widthM1 = '0, heightM1 = '0;
  logic [23:0] patFg = '0, patBg = '0;
  logic [63:0] monoPat = '0;
  logic patWe = 1'b0;
  logic [7:0] patAddr = '0, patData = '0;
  logic [MEM_AW-1:0] memAddr;
  logic memRe, memWe, busy, done, ropFault;
  logic [7:0] memWdata;
  logic [7:0] memRdata = '0;

  logic [7:0] vram  [MEMN];
  logic [7:0] model [MEMN];
  logic [7:0] benchTab [192];
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  blt_pixel_engine #(.MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdWord(cmdWord),
    .srcBase(srcBase), .dstBase(dstBase), .srcStride(srcStride),
    .dstStride(dstStride), .widthM1(widthM1), .heightM1(heightM1),
    .patFg(patFg), .patBg(patBg), .monoPat(monoPat), .patWe(patWe),
    .patAddr(patAddr), .patData(patData), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata), .busy(busy),
    .done(done), .ropFault(ropFault)
  );

  // byte memory, one-cycle read latency (R11)
  always @(posedge clk) begin
    if (memWe) vram[memAddr] <= memWdata;
    if (memRe) memRdata <= vram[memAddr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ternary code defined bitwise by truth-table index {P,S,D} (R4)
  function automatic logic [23:0] ropRef(input logic [7:0] c, input logic [23:0] s,
                                         input logic [23:0] d, input logic [23:0] p);
    logic [23:0] r;
    for (int j = 0; j < 24; j++) r[j] = c[{p[j], s[j], d[j]}];
    return r;
  endfunction

  function automatic bit ropOk(input logic [7:0] c);
    return c inside {8'h00, 8'h0A, 8'h22, 8'h55, 8'hB8, 8'hBB,
                     8'hCC, 8'hE2, 8'hEE, 8'hF0, 8'hFF};
  endfunction

  function automatic int pixBytes(input logic [31:0] cmd);
    return (cmd[4:2] == 3'd0) ? 1 : (cmd[4:2] == 3'd1) ? 2 : 3;
  endfunction

  task automatic modelRun(input logic [31:0] cmd, input logic [31:0] sb, input logic [31:0] db,
                          input logic [15:0] ss, input logic [15:0] ds,
                          input int w, input int h);
    int b = pixBytes(cmd);
    int sbm = int'(sb & 32'h003F_FFF8);
    int dbm = int'(db & 32'h003F_FFF8);
    int ssm = int'(ss & 16'hFFF8);
    int dsm = int'(ds & 16'hFFF8);
    logic [7:0] code = cmd[24:17];
    for (int y = 0; y <= h; y++) begin
      for (int x = 0; x <= w; x++) begin
        logic [23:0] s = '0, d = '0, p = '0, r;
        for (int i = 0; i < b; i++) begin
          s[i*8 +: 8] = model[(sbm + x*b + y*ssm + i) % MEMN];
          d[i*8 +: 8] = model[(dbm + x*b + y*dsm + i) % MEMN];
          if (cmd[8])
            p[i*8 +: 8] = monoPat[(y%8)*8 + 7 - (x%8)] ? patFg[i*8 +: 8] : patBg[i*8 +: 8];
          else
            p[i*8 +: 8] = benchTab[(y%8)*8*b + (x%8)*b + i];
        end
        r = ropRef(code, s, d, p);
        if (cmd[5] && ropOk(code))
          for (int i = 0; i < b; i++) model[(dbm + x*b + y*dsm + i) % MEMN] = r[i*8 +: 8];
      end
    end
  endtask

  task automatic loadPattern();
    for (int i = 0; i < 192; i++) begin
      benchTab[i] = 8'($urandom);
      @(negedge clk);
      patWe = 1'b1; patAddr = 8'(i); patData = benchTab[i];
    end
    @(negedge clk);
    patWe = 1'b0;
  endtask

  task automatic runCmd(input logic [31:0] cmd, input logic [31:0] sb, input logic [31:0] db,
                        input logic [15:0] ss, input logic [15:0] ds,
                        input int w, input int h, input string tag, input bit poke);
    int b = pixBytes(cmd);
    int per = 2*b + 2 + (cmd[5] ? b : 0);
    int expCyc = (w + 1) * (h + 1) * per;
    bit expFault = !ropOk(cmd[24:17]);
    int cyc, miss;
    for (int i = 0; i < MEMN; i++) model[i] = vram[i];
    modelRun(cmd, sb, db, ss, ds, w, h);
    @(negedge clk);
    cmdWord = cmd; srcBase = sb; dstBase = db; srcStride = ss; dstStride = ds;
    widthM1 = CW'(w); heightM1 = CW'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(ropFault == expFault, "R5", {tag, " fault flag after start"}, longint'(ropFault), longint'(expFault));
    while (done !== 1'b1 && cyc < LIMIT) begin
      if (poke && cyc == 2) begin
        start = 1'b1; cmdWord = {7'd0, 8'h00, 17'h00024}; dstBase = sb;
      end
      if (poke && cyc == 3) begin
        start = 1'b0; cmdWord = cmd; dstBase = db;
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc == expCyc, "R9", {tag, " cycles to done"}, longint'(cyc), longint'(expCyc));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", {tag, " done pulse ends, idle"},
        longint'({done, busy}), 0);
    chk(ropFault == expFault, "R5", {tag, " fault flag sticky"}, longint'(ropFault), longint'(expFault));
    miss = 0;
    for (int i = 0; i < MEMN; i++) if (vram[i] !== model[i]) miss++;
    chk(miss == 0, tag, "memory bytes differing from model", longint'(miss), 0);
  endtask

  function automatic logic [31:0] mkCmd(input int depth, input logic [7:0] rop,
                                        input bit draw, input bit mono);
    logic [31:0] c = $urandom;
    c[4:2] = 3'(depth); c[5] = draw; c[8] = mono; c[24:17] = rop;
    return c;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog expired: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] ropList [11] = '{8'h00, 8'h0A, 8'h22, 8'h55, 8'hB8, 8'hBB,
                                 8'hCC, 8'hE2, 8'hEE, 8'hF0, 8'hFF};
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMN; i++) vram[i] <= 8'($urandom);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, ropFault, memRe, memWe} == 5'b0, "R10", "reset outputs",
        longint'({busy, done, ropFault, memRe, memWe}), 0);
    rstN = 1'b1;
    loadPattern();
    patFg = 24'hA1B2C3; patBg = 24'h0F1E2D; monoPat = 64'h8142_2418_55AA_F00F;

    runCmd(mkCmd(0, 8'hCC, 1, 0), 32'h100, 32'h800, 16'h20, 16'h40, 5, 3, "R1 R11 copy8", 0);
    runCmd(mkCmd(1, 8'hF0, 1, 1), 32'h200, 32'h900, 16'h30, 16'h48, 9, 2, "R6 mono16", 0);
    runCmd(mkCmd(2, 8'hF0, 1, 0), 32'h300, 32'hA00, 16'h40, 16'h50, 11, 9, "R7 R8 colour24", 0);
    runCmd(mkCmd(1, 8'h55, 0, 0), 32'h400, 32'hB00, 16'h20, 16'h20, 4, 4, "R3 nodraw", 0);
    runCmd(mkCmd(0, 8'h5A, 1, 0), 32'h400, 32'hC00, 16'h10, 16'h10, 3, 2, "R5 badrop", 0);
    runCmd(mkCmd(0, 8'hEE, 1, 0), 32'h500, 32'hD00, 16'h10, 16'h18, 6, 3, "R10 busystart", 1);
    runCmd(mkCmd(2, 8'hE2, 1, 1), 32'hFFC3_FFFF, 32'h7FF, 16'hFFFF, 16'h1237, 4, 3, "R2 wrap", 0);
    runCmd(mkCmd(0, 8'hB8, 1, 1), 32'h600, 32'h600, 16'h08, 16'h10, 7, 3, "R4 overlap", 0);

    for (int n = 0; n < 30; n++) begin
      int depth = $urandom_range(0, 2);
      logic [7:0] rop = ($urandom_range(0, 9) == 0) ? 8'($urandom) : ropList[$urandom_range(0, 10)];
      bit draw = ($urandom_range(0, 5) != 0);
      bit mono = 1'($urandom);
      if (n % 6 == 0) loadPattern();
      patFg = 24'($urandom); patBg = 24'($urandom); monoPat = {$urandom, $urandom};
      runCmd(mkCmd(depth, rop, draw, mono), $urandom, $urandom, 16'($urandom),
             16'($urandom), $urandom_range(0, 9), $urandom_range(0, 5), "R4 random", 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule